// File: doc/BRIEF.md
# Pattern-driven local bus address and sample controller

This block steps through a user-loaded pattern of microcode words. Each word governs one bus-clock cycle of a multiplexed local bus. For every word, the block chooses where the address comes from. The choices are the running column address of the transaction, a row form of the transaction address shifted by a mode setting, or an external memory-address register. The block then drives the three low address lines from that choice. When the address source changes between words, the block inserts a latch-enable address phase on the 24-bit multiplexed bus. For read transactions it also decides whether incoming data is captured mid-cycle on the falling clock edge or at the end of the cycle on the rising edge.

The pattern memory is a plain register array with a write port. A transaction is started by a one-cycle request while the block is idle. The request names the read/write direction, the transaction address and the index of the first pattern word. Execution runs until a word marked as last has executed.

Top module: `pat_bus_ctrl`

## Requirements
- R1: A pattern word is 13 bits: gpl in [5:0], dly in [6], smp in [7], inc in [8], src in [10:9], rep in [11], fin in [12]. The src field selects the address. 00 selects the running column address. 01 selects the row address, which is the transaction address shifted right by ROW_BASE plus the 2-bit `row_mode_i` (ROW_BASE defaults to 8). Values 10 and 11 select `mar_i`.
- R2: While busy, `la_low_o` equals bits [2:0] of the selected address in both address phases and execution cycles. While idle it is 0.
- R3: When a word with inc=1 executes, the running column address increments by one. The increment shows only through src=00; the row address and `mar_i` are unaffected.
- R4: An address phase precedes the first word of a pattern. One also precedes any word whose src differs from that of the previously executed word. During the phase `lad_o` carries the full selected address. At all other times `lad_o` is 0.
- R5: `ale_o` stays high for `ale_opt_i + ale_ratio_i + 1` consecutive cycles. The word then executes in the next cycle.
- R6: `gpl_o` equals the current word's gpl field in its address phase and in its execution cycle. While idle it is 0.
- R7: On a read transaction, a word with smp=1, dly=1 and `dly_mode_i`=1 captures `rd_data_i` at the falling edge in the middle of its execution cycle. The value appears on `rdata_o`, with `rvalid_o` high, for exactly the next cycle.
- R8: On a read transaction, a word with smp=1 in any other case captures `rd_data_i` at the rising edge that ends its execution cycle. The result and `rvalid_o` appear in the next cycle. Write transactions and words with smp=0 capture nothing.
- R9: A word with both fin=1 and rep=1 is not executed. `illegal_o` is high in that cycle, no data is captured, and the block is idle in the next cycle.
- R10: A word with rep=1 and fin=0 executes in two consecutive cycles, with no address phase between them. Its inc and smp actions apply in each of the two cycles.
- R11: After a word with fin=1 executes, `busy_o` is low in the next cycle. A request raised while busy is ignored.
- R12: After reset, the block is idle and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pw_en_i | input | 1 | Pattern memory write strobe |
| pw_addr_i | input | PAT_AW | Pattern memory write index |
| pw_data_i | input | 13 | Pattern word to write |
| req_i | input | 1 | Start a transaction (taken only while idle) |
| req_rd_i | input | 1 | 1 = read transaction |
| req_addr_i | input | ADDR_W | Transaction address |
| req_start_i | input | PAT_AW | Index of first pattern word |
| mar_i | input | ADDR_W | Memory-address register contents |
| row_mode_i | input | 2 | Extra right shift for the row address |
| dly_mode_i | input | 1 | Enables mid-cycle capture through the dly bit |
| ale_opt_i | input | 2 | Option part of the latch-enable length |
| ale_ratio_i | input | 1 | Clock-ratio part of the latch-enable length |
| rd_data_i | input | DATA_W | Read data from the bus |
| busy_o | output | 1 | Pattern in progress |
| ale_o | output | 1 | Address latch enable |
| lad_o | output | ADDR_W | Multiplexed address/data bus, address value |
| la_low_o | output | 3 | Low address lines |
| gpl_o | output | 6 | General-purpose lines |
| rdata_o | output | DATA_W | Captured read data |
| rvalid_o | output | 1 | Captured data valid pulse |
| illegal_o | output | 1 | Illegal word flag |

## Verification
Each cycle, a bench model compares every port with values it expects from its own walk of the pattern.
- A wrong running column address or source choice shows on `la_low_o` in the same cycle. During address phases it also shows on the full `lad_o`.
- A wrong record of the previous source either drops or adds a latch-enable phase. Every later cycle of that pattern then shifts by the phase length.
- An error in the capture-edge choice shows one cycle later as the wrong half-cycle value on `rdata_o`.
- A lost redo or last marker changes the cycle in which `busy_o` falls.

// File: rtl/pbc_pkg.sv
// Shared types for the pattern-driven bus controller.
// Assumes a fixed 6-line general-purpose field in every pattern word.
package pbc_pkg;
    localparam int GPL_W = 6;

    // One pattern word; bit positions are part of the programming model.
    typedef struct packed {
        logic             fin;   // last word of pattern
        logic             rep;   // execute this word twice
        logic [1:0]       src;   // address source select
        logic             inc;   // increment column address
        logic             smp;   // capture read data
        logic             dly;   // mid-cycle capture request
        logic [GPL_W-1:0] gpl;   // general-purpose line values
    } pword_t;

    localparam int WORD_W = $bits(pword_t);

    typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_EXEC} sq_state_t;
endpackage

// File: rtl/pbc_pattern_mem.sv
// Pattern store: register array with one write port and two
// combinational read ports (current word and following word).
// Assumes writes happen only while the sequencer is idle.
module pbc_pattern_mem import pbc_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  pword_t        wr_word_i,
    input  logic [AW-1:0] rd_a_addr_i,
    input  logic [AW-1:0] rd_b_addr_i,
    output pword_t        rd_a_word_o,
    output pword_t        rd_b_word_o
);
    pword_t mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Update one entry on a matching write, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en_i && (wr_addr_i == AW'(g)))
                mem_q[g] <= wr_word_i;
        end
    end

    // Read both ports without a register stage.
    always_comb begin
        rd_a_word_o = mem_q[rd_a_addr_i];
        rd_b_word_o = mem_q[rd_b_addr_i];
    end
endmodule

// File: rtl/pbc_addr_sel.sv
// Address source multiplexer: column address, row address (shifted
// transaction address), or the memory-address register.
// Assumes ROW_BASE + 3 < ADDR_W.
module pbc_addr_sel #(
    parameter int ADDR_W   = 24,
    parameter int ROW_BASE = 8
) (
    input  logic [1:0]        src_i,
    input  logic [ADDR_W-1:0] col_addr_i,
    input  logic [ADDR_W-1:0] txn_addr_i,
    input  logic [1:0]        row_mode_i,
    input  logic [ADDR_W-1:0] mar_i,
    output logic [ADDR_W-1:0] sel_addr_o
);
    localparam int NROW = 4;
    logic [ADDR_W-1:0] row_cand [NROW];

    for (genvar g = 0; g < NROW; g++) begin : g_row
        assign row_cand[g] = txn_addr_i >> (ROW_BASE + g);
    end

    // Pick the source named by the word's select field.
    always_comb begin
        unique case (src_i)
            2'b00:   sel_addr_o = col_addr_i;
            2'b01:   sel_addr_o = row_cand[row_mode_i];
            default: sel_addr_o = mar_i;
        endcase
    end
endmodule

// File: rtl/pbc_sequencer.sv
// Pattern sequencer: accepts a request while idle, runs address phases
// on source changes, executes words, handles repeat and illegal words.
// Assumes ale_len_i is at least 1 and stable during a transaction.
module pbc_sequencer import pbc_pkg::*; #(
    parameter int ADDR_W = 24,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_rd_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [AW-1:0]     req_start_i,
    input  logic              w_fin_i,
    input  logic              w_rep_i,
    input  logic              w_inc_i,
    input  logic [1:0]        w_src_i,
    input  logic [1:0]        nxt_src_i,
    input  logic [2:0]        ale_len_i,
    output logic [AW-1:0]     pc_o,
    output logic [AW-1:0]     nxt_pc_o,
    output logic [ADDR_W-1:0] col_addr_o,
    output logic [ADDR_W-1:0] txn_addr_o,
    output logic              rd_txn_o,
    output logic              busy_o,
    output logic              ale_o,
    output logic              exec_o,
    output logic              illegal_o
);
    sq_state_t         st_q;
    logic [AW-1:0]     pc_q;
    logic [ADDR_W-1:0] col_q, txn_q;
    logic              rd_q, rep_done_q;
    logic [2:0]        cnt_q;
    logic              bad_word;

    assign bad_word = w_fin_i && w_rep_i;

    // Advance the pattern state machine once per bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= SQ_IDLE;
            pc_q       <= '0;
            col_q      <= '0;
            txn_q      <= '0;
            rd_q       <= 1'b0;
            rep_done_q <= 1'b0;
            cnt_q      <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (req_i) begin
                        txn_q      <= req_addr_i;
                        col_q      <= req_addr_i;
                        rd_q       <= req_rd_i;
                        pc_q       <= req_start_i;
                        rep_done_q <= 1'b0;
                        cnt_q      <= '0;
                        st_q       <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    if (cnt_q == ale_len_i - 3'd1)
                        st_q <= SQ_EXEC;
                    else
                        cnt_q <= cnt_q + 3'd1;
                end
                default: begin
                    if (bad_word) begin
                        st_q <= SQ_IDLE;
                    end else begin
                        if (w_inc_i)
                            col_q <= col_q + ADDR_W'(1);
                        if (w_rep_i && !rep_done_q) begin
                            rep_done_q <= 1'b1;
                        end else begin
                            rep_done_q <= 1'b0;
                            if (w_fin_i) begin
                                st_q <= SQ_IDLE;
                            end else begin
                                pc_q <= pc_q + AW'(1);
                                if (nxt_src_i != w_src_i) begin
                                    cnt_q <= '0;
                                    st_q  <= SQ_ADDR;
                                end
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Decode state into control outputs.
    always_comb begin
        pc_o       = pc_q;
        nxt_pc_o   = pc_q + AW'(1);
        col_addr_o = col_q;
        txn_addr_o = txn_q;
        rd_txn_o   = rd_q;
        busy_o     = (st_q != SQ_IDLE);
        ale_o      = (st_q == SQ_ADDR);
        exec_o     = (st_q == SQ_EXEC) && !bad_word;
        illegal_o  = (st_q == SQ_EXEC) && bad_word;
    end

    // R9
    illegal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !busy_o);
    // R5
    ale_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale_o) && busy_o) |-> (st_q == SQ_EXEC));
    // R10
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && w_rep_i && !rep_done_q) |=> (exec_o && $stable(pc_q)));
    // R11
    busy_req_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> $stable(txn_q));
endmodule

// File: rtl/pbc_sample.sv
// Read data capture: rising-edge capture at end of cycle, or a
// falling-edge holding register moved to the rising edge afterwards.
// Assumes cap_en_i and fall_sel_i are stable from rising edge to rising edge.
module pbc_sample #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              cap_en_i,
    input  logic              fall_sel_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    logic [DATA_W-1:0] mid_q;

    // Mid-cycle capture on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)
            mid_q <= '0;
        else if (cap_en_i && fall_sel_i)
            mid_q <= rd_data_i;
    end

    // Present captured data on the rising edge with a valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= cap_en_i;
            if (cap_en_i)
                rdata_o <= fall_sel_i ? mid_q : rd_data_i;
        end
    end

    // R8
    valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(busy_i));
endmodule

// File: rtl/pat_bus_ctrl.sv
// Top of the pattern-driven bus controller: pattern store, sequencer,
// address source select and read-data capture.
// Assumes pattern writes only while idle and configuration held per transaction.
module pat_bus_ctrl import pbc_pkg::*; #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int PAT_DEPTH = 16,
    parameter int ROW_BASE  = 8,
    localparam int PAT_AW   = $clog2(PAT_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pw_en_i,
    input  logic [PAT_AW-1:0] pw_addr_i,
    input  logic [WORD_W-1:0] pw_data_i,
    input  logic              req_i,
    input  logic              req_rd_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [PAT_AW-1:0] req_start_i,
    input  logic [ADDR_W-1:0] mar_i,
    input  logic [1:0]        row_mode_i,
    input  logic              dly_mode_i,
    input  logic [1:0]        ale_opt_i,
    input  logic              ale_ratio_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              ale_o,
    output logic [ADDR_W-1:0] lad_o,
    output logic [2:0]        la_low_o,
    output logic [GPL_W-1:0]  gpl_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              illegal_o
);
    pword_t            cur_w, nxt_w;
    logic [PAT_AW-1:0] pc, nxt_pc;
    logic [ADDR_W-1:0] col_addr, txn_addr, sel_addr;
    logic              rd_txn, busy, ale, exec;
    logic [2:0]        ale_len;

    assign ale_len = 3'(ale_opt_i) + 3'(ale_ratio_i) + 3'd1;

    pbc_pattern_mem #(.DEPTH(PAT_DEPTH), .AW(PAT_AW)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(pw_en_i), .wr_addr_i(pw_addr_i), .wr_word_i(pword_t'(pw_data_i)),
        .rd_a_addr_i(pc), .rd_b_addr_i(nxt_pc),
        .rd_a_word_o(cur_w), .rd_b_word_o(nxt_w)
    );

    pbc_sequencer #(.ADDR_W(ADDR_W), .AW(PAT_AW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .req_rd_i(req_rd_i), .req_addr_i(req_addr_i),
        .req_start_i(req_start_i),
        .w_fin_i(cur_w.fin), .w_rep_i(cur_w.rep), .w_inc_i(cur_w.inc),
        .w_src_i(cur_w.src), .nxt_src_i(nxt_w.src), .ale_len_i(ale_len),
        .pc_o(pc), .nxt_pc_o(nxt_pc), .col_addr_o(col_addr), .txn_addr_o(txn_addr),
        .rd_txn_o(rd_txn), .busy_o(busy), .ale_o(ale), .exec_o(exec),
        .illegal_o(illegal_o)
    );

    pbc_addr_sel #(.ADDR_W(ADDR_W), .ROW_BASE(ROW_BASE)) asel_i (
        .src_i(cur_w.src), .col_addr_i(col_addr), .txn_addr_i(txn_addr),
        .row_mode_i(row_mode_i), .mar_i(mar_i), .sel_addr_o(sel_addr)
    );

    pbc_sample #(.DATA_W(DATA_W)) smp_i (
        .clk(clk), .rst_n(rst_n), .busy_i(busy),
        .cap_en_i(exec && rd_txn && cur_w.smp),
        .fall_sel_i(dly_mode_i && cur_w.dly),
        .rd_data_i(rd_data_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    // Drive bus outputs from the sequencer phase and selected address.
    always_comb begin
        busy_o   = busy;
        ale_o    = ale;
        lad_o    = ale ? sel_addr : '0;
        la_low_o = busy ? sel_addr[2:0] : 3'd0;
        gpl_o    = busy ? cur_w.gpl : '0;
    end

    // R6
    ale_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> busy_o);
    // R9
    illegal_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !rvalid_o);
endmodule

// File: tb/pat_bus_ctrl_tb_top.sv
module pat_bus_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    typedef struct {
        bit          busy, ale, rv, ill;
        logic [23:0] lad;
        logic [2:0]  low;
        logic [5:0]  gpl;
        logic [15:0] rd;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic pw_en_i = 0; logic [3:0] pw_addr_i = 0; logic [12:0] pw_data_i = 0;
    logic req_i = 0, req_rd_i = 0; logic [23:0] req_addr_i = 0; logic [3:0] req_start_i = 0;
    logic [23:0] mar_i = 0; logic [1:0] row_mode_i = 0; logic dly_mode_i = 0;
    logic [1:0] ale_opt_i = 0; logic ale_ratio_i = 0; logic [15:0] rd_data_i = 0;
    logic busy_o, ale_o, rvalid_o, illegal_o;
    logic [23:0] lad_o; logic [2:0] la_low_o; logic [5:0] gpl_o; logic [15:0] rdata_o;

    int vectors = 0, errors = 0, cyc = 0;
    exp_t exp_q[$];
    logic [12:0] bpat [16];
    bit pend_v; logic [15:0] pend_d; int nput;

    pat_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pw_en_i(pw_en_i), .pw_addr_i(pw_addr_i),
        .pw_data_i(pw_data_i), .req_i(req_i), .req_rd_i(req_rd_i),
        .req_addr_i(req_addr_i), .req_start_i(req_start_i), .mar_i(mar_i),
        .row_mode_i(row_mode_i), .dly_mode_i(dly_mode_i), .ale_opt_i(ale_opt_i),
        .ale_ratio_i(ale_ratio_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .ale_o(ale_o), .lad_o(lad_o), .la_low_o(la_low_o), .gpl_o(gpl_o),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .illegal_o(illegal_o)
    );

    always #(HALF) clk = ~clk;

    function automatic logic [15:0] fdat(int c, int h);
        return 16'(16'h3000 + c * 2 + h);
    endfunction

    // Word helper, layout per R1.
    function automatic logic [12:0] mkw(bit fin, bit rep, logic [1:0] src, bit inc,
                                        bit smp, bit dly, logic [5:0] gpl);
        return {fin, rep, src, inc, smp, dly, gpl};
    endfunction

    function automatic logic [23:0] fsel(logic [1:0] src, logic [23:0] col, logic [23:0] txn);
        if (src == 2'b00) return col;
        if (src == 2'b01) return txn >> (8 + int'(row_mode_i));
        return mar_i;
    endfunction

    function automatic void put(exp_t e);
        if (pend_v) begin e.rv = 1; e.rd = pend_d; pend_v = 0; end
        exp_q.push_back(e);
        nput++;
    endfunction

    // Behavioural walk of the pattern producing one entry per cycle.
    function automatic void build(int r, bit rd, logic [23:0] addr, int start);
        exp_t idle = '{default: 0};
        exp_t e;
        int pc = start, prev = -1, alen;
        logic [23:0] cur = addr, s;
        logic [12:0] w;
        alen = int'(ale_opt_i) + int'(ale_ratio_i) + 1;
        nput = 0; pend_v = 0;
        put(idle);
        for (int it = 0; it < 64; it++) begin
            w = bpat[pc];
            if (int'(w[10:9]) != prev) begin
                s = fsel(w[10:9], cur, addr);
                for (int k = 0; k < alen; k++) begin
                    e = '{default: 0}; e.busy = 1; e.ale = 1; e.lad = s;
                    e.low = s[2:0]; e.gpl = w[5:0];
                    put(e);
                end
            end
            prev = int'(w[10:9]);
            if (w[12] && w[11]) begin
                s = fsel(w[10:9], cur, addr);
                e = '{default: 0}; e.busy = 1; e.ill = 1; e.low = s[2:0]; e.gpl = w[5:0];
                put(e);
                break;
            end
            for (int rp = 0; rp < (w[11] ? 2 : 1); rp++) begin
                int here;
                s = fsel(w[10:9], cur, addr);
                e = '{default: 0}; e.busy = 1; e.low = s[2:0]; e.gpl = w[5:0];
                here = r + nput;
                put(e);
                if (rd && w[7]) begin
                    pend_v = 1;
                    pend_d = fdat(here, (dly_mode_i && w[6]) ? 0 : 1);
                end
                if (w[8]) cur = cur + 24'd1;
            end
            if (w[12]) break;
            pc = (pc + 1) % 16;
        end
        put(idle);
    endfunction

    task automatic check(bit ok, string tag, string fld, logic [31:0] act, logic [31:0] expv);
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, fld, cyc, act, expv);
        end
    endtask

    // Data driver and per-cycle comparator.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk); #1;
            rd_data_i = fdat(cyc, 0);
            #(HALF); rd_data_i = fdat(cyc, 1);
            #(HALF - 2);
            if (rst_n) begin
                e = '{default: 0};
                if (exp_q.size() > 0) e = exp_q.pop_front();
                vectors++;
                check(busy_o == e.busy, "R10 R11 R12", "busy", 32'(busy_o), 32'(e.busy));
                check(ale_o == e.ale, "R5", "ale", 32'(ale_o), 32'(e.ale));
                check(lad_o == e.lad, "R4", "lad", 32'(lad_o), 32'(e.lad));
                check(la_low_o == e.low, "R1 R2 R3", "la_low", 32'(la_low_o), 32'(e.low));
                check(gpl_o == e.gpl, "R6", "gpl", 32'(gpl_o), 32'(e.gpl));
                check(rvalid_o == e.rv, "R7 R8", "rvalid", 32'(rvalid_o), 32'(e.rv));
                if (e.rv)
                    check(rdata_o == e.rd, "R7 R8", "rdata", 32'(rdata_o), 32'(e.rd));
                check(illegal_o == e.ill, "R9", "illegal", 32'(illegal_o), 32'(e.ill));
            end
            cyc++;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic load(int idx, logic [12:0] w);
        bpat[idx] = w;
        pw_en_i = 1; pw_addr_i = 4'(idx); pw_data_i = w;
        step();
        pw_en_i = 0;
    endtask

    task automatic run(bit rd, logic [23:0] addr, int start, int poke);
        build(cyc, rd, addr, start);
        req_i = 1; req_rd_i = rd; req_addr_i = addr; req_start_i = 4'(start);
        step();
        req_i = 0;
        if (poke > 0) begin
            // R11: request while busy must not disturb the running pattern.
            repeat (poke) step();
            req_i = 1; req_rd_i = ~rd; req_addr_i = ~addr; req_start_i = 4'(start + 3);
            step();
            req_i = 0;
        end
        while (exp_q.size() != 0) step();
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;   // R12: idle outputs checked from here on
        step(); step();
        for (int i = 0; i < 16; i++) load(i, '0);

        // R1 R2 R4 R5 R6: each source, phase on every change, shortest latch enable.
        mar_i = 24'h5A_C3_E5; row_mode_i = 2'd1;
        load(0, mkw(0, 0, 2'b00, 0, 0, 0, 6'h01));
        load(1, mkw(0, 0, 2'b01, 0, 0, 0, 6'h12));
        load(2, mkw(0, 0, 2'b10, 0, 0, 0, 6'h23));
        load(3, mkw(0, 0, 2'b11, 0, 0, 0, 6'h34));
        load(4, mkw(1, 0, 2'b11, 0, 0, 0, 6'h3F));
        run(0, 24'hAB_CD_E7, 0, 0);

        // R3 R5: increments through column source, longest latch enable, row mode 3.
        ale_opt_i = 2'd3; ale_ratio_i = 1'b1; row_mode_i = 2'd3;
        load(5, mkw(0, 0, 2'b00, 1, 0, 0, 6'h05));
        load(6, mkw(0, 0, 2'b00, 1, 0, 0, 6'h06));
        load(7, mkw(0, 0, 2'b01, 1, 0, 0, 6'h07));
        load(8, mkw(0, 0, 2'b00, 1, 0, 0, 6'h08));
        load(9, mkw(1, 0, 2'b00, 0, 0, 0, 6'h09));
        run(1, 24'h12_34_56, 5, 0);

        // R7 R8: mixed capture edges with the delay mode on, then off, then a write.
        ale_opt_i = 2'd1; ale_ratio_i = 1'b0; row_mode_i = 2'd0;
        load(10, mkw(0, 0, 2'b00, 1, 1, 1, 6'h0A));
        load(11, mkw(0, 0, 2'b00, 0, 1, 0, 6'h0B));
        load(12, mkw(0, 0, 2'b10, 0, 0, 1, 6'h0C));
        load(13, mkw(0, 0, 2'b10, 0, 1, 1, 6'h0D));
        load(14, mkw(1, 0, 2'b01, 0, 1, 1, 6'h0E));
        dly_mode_i = 1;
        run(1, 24'h00_0F_F3, 10, 0);
        dly_mode_i = 0;
        run(1, 24'h70_00_01, 10, 0);
        run(0, 24'h70_00_01, 10, 0);

        // R10: repeated word with increment and capture, then a following word.
        ale_opt_i = 2'd0; dly_mode_i = 1;
        load(0, mkw(0, 1, 2'b00, 1, 1, 1, 6'h2A));
        load(1, mkw(0, 1, 2'b00, 0, 1, 0, 6'h2B));
        load(2, mkw(1, 0, 2'b01, 0, 1, 0, 6'h2C));
        run(1, 24'h44_44_46, 0, 0);

        // R9: last and repeat together, reached after one good word; then reached first.
        load(3, mkw(0, 0, 2'b10, 0, 1, 0, 6'h11));
        load(4, mkw(1, 1, 2'b10, 0, 1, 1, 6'h22));
        run(1, 24'h01_02_03, 3, 0);
        run(1, 24'h01_02_03, 4, 0);

        // R11: start index wraps past the end, request during busy ignored.
        ale_ratio_i = 1;
        load(15, mkw(0, 0, 2'b01, 0, 1, 0, 6'h15));
        load(0, mkw(0, 0, 2'b01, 1, 1, 1, 6'h16));
        load(1, mkw(1, 0, 2'b00, 0, 1, 0, 6'h17));
        run(1, 24'hFE_DC_BA, 15, 2);
        run(1, 24'h00_00_07, 0, 1);

        step(); step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule